// File: doc/BRIEF.md
# Significance-Field Swap Repair Unit

This unit sits between a datapath and a word-organized RAM of `ROWS` rows and repairs faulty rows without spare cells or a local code. Each stored word carries a high-significance field, whose corruption hurts the downstream decoder, and an equally wide low-significance field, whose corruption costs little. During self-test the unit watches the mismatch flag, the row under test and the error word from the memory tester. It marks a row as repairable when the errors lie only in the high field. During functional operation every write and every read row is looked up in that mark register. For a marked row the two fields trade places on the way into the RAM and trade back on the way out. Sensitive bits therefore land in the healthy cells, and the damaged cells hold the bits that matter least.

The mark register holds one flag per group of `ROWS_PER_BIT` consecutive rows. This trades register area against repair precision. The swap is one level of 2-to-1 multiplexers and adds no cycle of latency. The default word is a 15-bit segment: I[5:0] in bits 14..9, Q[5:0] in bits 8..3 and a 3-bit channel-quality value CN[2:0] in bits 2..0.

Top module: `faultSwapRepair`

## Requirements
- R1: The mark register holds ceil(ROWS/ROWS_PER_BIT) flags. Row r uses flag floor(r/ROWS_PER_BIT), so all rows of one group share a flag.
- R2: After reset (rstN low) every flag is 0, and every row passes data unchanged in both directions.
- R3: A low-to-high change of testMode clears all flags at the next clock edge. A capture that qualifies in that same cycle still sets its own flag.
- R4: While testMode is 1 and bistErr is 1, the flag of bistRow is set at the clock edge when bistErrWord has at least one 1 in the high field and none in the low field. The high field is bits {14,13,12,8,7,6,2}. The low field is bits {11,10,9,5,4,3,1}.
- R5: The flag is left unchanged when the error word hits only the low field, hits both fields, or hits neither field, and also when bistErr is 0.
- R6: In functional mode (testMode 0), a write to a marked row drives ramWrData with each high bit exchanged with its partner low bit. The pairs are 14-11, 13-10, 12-9, 8-5, 7-4, 6-3 and 2-1. The swap is combinational, in the same cycle.
- R7: In functional mode, a read from a marked row applies the same exchange to ramRdData. Data written to a marked row therefore reads back in its original order.
- R8: Unmarked rows, and every access while testMode is 1, pass data unchanged.
- R9: Bits outside both fields (bit 0) are never moved.
- R10: A set flag stays set through functional operation and through later captures, until the next entry into test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testMode | input | 1 | 1 = self-test session, 0 = functional |
| bistErr | input | 1 | Tester mismatch flag for the current row |
| bistRow | input | ROW_W | Row under test |
| bistErrWord | input | DATA_W | Failing-bit positions of the current row |
| wrRow | input | ROW_W | Row of the functional write |
| wrData | input | DATA_W | Write data from the datapath |
| ramWrData | output | DATA_W | Write data toward the RAM |
| rdRow | input | ROW_W | Row of the functional read |
| ramRdData | input | DATA_W | Read data from the RAM |
| rdData | output | DATA_W | Read data toward the datapath |

## Verification
Two events can land on the same clock edge: entry into test mode, which clears every flag, and a qualifying capture, which sets one flag. The bench raises testMode and bistErr at the same negative edge. It then checks two things in functional mode: the captured row swaps, and a row flagged in the earlier session no longer swaps. The bench also drives a write and a read to different rows in the same cycle, one marked and one not, and checks that each direction uses its own row's flag.

// File: rtl/repairPkg.sv
package repairPkg;

  localparam int DEF_DATA_W  = 15;
  localparam int DEF_FIELD_W = 7;

  // default segment: I[5:0]=14..9, Q[5:0]=8..3, CN[2:0]=2..0
  localparam int DEF_HI_POS [DEF_FIELD_W] = '{14, 13, 12, 8, 7, 6, 2};
  localparam int DEF_LO_POS [DEF_FIELD_W] = '{11, 10, 9, 5, 4, 3, 1};

  typedef struct packed {
    logic clearAll;
    logic setEn;
  } repairStrobes_t;

endpackage

// File: rtl/repairCtrl.sv
module repairCtrl
  import repairPkg::*;
#(
  parameter int ROWS         = 1024,
  parameter int ROWS_PER_BIT = 1,
  parameter int DATA_W       = DEF_DATA_W,
  parameter int FIELD_W      = DEF_FIELD_W,
  parameter int HI_POS [FIELD_W] = DEF_HI_POS,
  parameter int LO_POS [FIELD_W] = DEF_LO_POS,
  localparam int ROW_W      = $clog2(ROWS),
  localparam int FAULT_BITS = (ROWS + ROWS_PER_BIT - 1) / ROWS_PER_BIT,
  localparam int IDX_W      = (FAULT_BITS > 1) ? $clog2(FAULT_BITS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testMode,
  input  logic              bistErr,
  input  logic [ROW_W-1:0]  bistRow,
  input  logic [DATA_W-1:0] bistErrWord,
  output repairStrobes_t    strobes,
  output logic [IDX_W-1:0]  setIdx
);

  logic              testModeQ;
  logic [DATA_W-1:0] hiMask;
  logic [DATA_W-1:0] loMask;
  logic              hiHit;
  logic              loHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) testModeQ <= 1'b0;
    else       testModeQ <= testMode;
  end

  always_comb begin
    hiMask = '0;
    loMask = '0;
    for (int k = 0; k < FIELD_W; k++) begin
      hiMask[HI_POS[k]] = 1'b1;
      loMask[LO_POS[k]] = 1'b1;
    end
  end

  assign hiHit = |(bistErrWord & hiMask);
  assign loHit = |(bistErrWord & loMask);

  assign strobes.clearAll = testMode & ~testModeQ;
  assign strobes.setEn    = testMode & bistErr & hiHit & ~loHit;
  assign setIdx           = IDX_W'(32'(bistRow) / ROWS_PER_BIT);

endmodule

// File: rtl/fieldSwap.sv
module fieldSwap
  import repairPkg::*;
#(
  parameter int DATA_W  = DEF_DATA_W,
  parameter int FIELD_W = DEF_FIELD_W,
  parameter int HI_POS [FIELD_W] = DEF_HI_POS,
  parameter int LO_POS [FIELD_W] = DEF_LO_POS
) (
  input  logic [DATA_W-1:0] din,
  input  logic              swapEn,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] crossed;

  always_comb begin
    crossed = din;
    for (int k = 0; k < FIELD_W; k++) begin
      crossed[HI_POS[k]] = din[LO_POS[k]];
      crossed[LO_POS[k]] = din[HI_POS[k]];
    end
  end

  // single 2-to-1 mux level
  assign dout = swapEn ? crossed : din;

endmodule

// File: rtl/repairDatapath.sv
module repairDatapath
  import repairPkg::*;
#(
  parameter int ROWS         = 1024,
  parameter int ROWS_PER_BIT = 1,
  parameter int DATA_W       = DEF_DATA_W,
  parameter int FIELD_W      = DEF_FIELD_W,
  parameter int HI_POS [FIELD_W] = DEF_HI_POS,
  parameter int LO_POS [FIELD_W] = DEF_LO_POS,
  localparam int ROW_W      = $clog2(ROWS),
  localparam int FAULT_BITS = (ROWS + ROWS_PER_BIT - 1) / ROWS_PER_BIT,
  localparam int IDX_W      = (FAULT_BITS > 1) ? $clog2(FAULT_BITS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  testMode,
  input  repairStrobes_t        strobes,
  input  logic [IDX_W-1:0]      setIdx,
  input  logic [ROW_W-1:0]      wrRow,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     ramWrData,
  input  logic [ROW_W-1:0]      rdRow,
  input  logic [DATA_W-1:0]     ramRdData,
  output logic [DATA_W-1:0]     rdData,
  output logic [FAULT_BITS-1:0] faultBits
);

  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;
  logic             wrSwap;
  logic             rdSwap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultBits <= '0;
    end else begin
      if (strobes.clearAll) faultBits <= '0;
      if (strobes.setEn)    faultBits[setIdx] <= 1'b1;
    end
  end

  assign wrIdx  = IDX_W'(32'(wrRow) / ROWS_PER_BIT);
  assign rdIdx  = IDX_W'(32'(rdRow) / ROWS_PER_BIT);
  assign wrSwap = ~testMode & faultBits[wrIdx];
  assign rdSwap = ~testMode & faultBits[rdIdx];

  fieldSwap #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .HI_POS(HI_POS), .LO_POS(LO_POS)
  ) wrSwap_i (
    .din(wrData), .swapEn(wrSwap), .dout(ramWrData)
  );

  fieldSwap #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .HI_POS(HI_POS), .LO_POS(LO_POS)
  ) rdSwap_i (
    .din(ramRdData), .swapEn(rdSwap), .dout(rdData)
  );

endmodule

// File: rtl/faultSwapRepair.sv
module faultSwapRepair
  import repairPkg::*;
#(
  parameter int ROWS         = 1024,
  parameter int ROWS_PER_BIT = 1,
  parameter int DATA_W       = DEF_DATA_W,
  parameter int FIELD_W      = DEF_FIELD_W,
  parameter int HI_POS [FIELD_W] = DEF_HI_POS,
  parameter int LO_POS [FIELD_W] = DEF_LO_POS,
  localparam int ROW_W      = $clog2(ROWS),
  localparam int FAULT_BITS = (ROWS + ROWS_PER_BIT - 1) / ROWS_PER_BIT,
  localparam int IDX_W      = (FAULT_BITS > 1) ? $clog2(FAULT_BITS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testMode,
  input  logic              bistErr,
  input  logic [ROW_W-1:0]  bistRow,
  input  logic [DATA_W-1:0] bistErrWord,
  input  logic [ROW_W-1:0]  wrRow,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] ramWrData,
  input  logic [ROW_W-1:0]  rdRow,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] rdData
);

  repairStrobes_t          strobes;
  logic [IDX_W-1:0]        setIdx;
  logic [FAULT_BITS-1:0]   faultBits;

  repairCtrl #(
    .ROWS(ROWS), .ROWS_PER_BIT(ROWS_PER_BIT), .DATA_W(DATA_W),
    .FIELD_W(FIELD_W), .HI_POS(HI_POS), .LO_POS(LO_POS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .testMode(testMode), .bistErr(bistErr),
    .bistRow(bistRow), .bistErrWord(bistErrWord),
    .strobes(strobes), .setIdx(setIdx)
  );

  repairDatapath #(
    .ROWS(ROWS), .ROWS_PER_BIT(ROWS_PER_BIT), .DATA_W(DATA_W),
    .FIELD_W(FIELD_W), .HI_POS(HI_POS), .LO_POS(LO_POS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .testMode(testMode), .strobes(strobes),
    .setIdx(setIdx), .wrRow(wrRow), .wrData(wrData), .ramWrData(ramWrData),
    .rdRow(rdRow), .ramRdData(ramRdData), .rdData(rdData),
    .faultBits(faultBits)
  );

endmodule

// File: rtl/repairChecker.sv
module repairChecker #(
  parameter int DATA_W     = 15,
  parameter int FIELD_W    = 7,
  parameter int FAULT_BITS = 1024,
  parameter int HI_POS [FIELD_W] = '{14, 13, 12, 8, 7, 6, 2},
  parameter int LO_POS [FIELD_W] = '{11, 10, 9, 5, 4, 3, 1}
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  testMode,
  input logic                  bistErr,
  input logic [DATA_W-1:0]     bistErrWord,
  input logic [DATA_W-1:0]     wrData,
  input logic [DATA_W-1:0]     ramWrData,
  input logic [DATA_W-1:0]     ramRdData,
  input logic [DATA_W-1:0]     rdData,
  input logic [FAULT_BITS-1:0] faultBits
);

  logic [DATA_W-1:0] keepMask;
  logic [DATA_W-1:0] loMask;
  logic              prevTm;

  always_comb begin
    keepMask = '1;
    loMask   = '0;
    for (int k = 0; k < FIELD_W; k++) begin
      keepMask[HI_POS[k]] = 1'b0;
      keepMask[LO_POS[k]] = 1'b0;
      loMask[LO_POS[k]]   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevTm <= 1'b0;
    else       prevTm <= testMode;
  end

  // R3
  entry_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && !prevTm && !bistErr) |=> (faultBits == '0));

  // R5
  low_hit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && prevTm && bistErr && |(bistErrWord & loMask))
      |=> (faultBits == $past(faultBits)));

  // R10
  func_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !testMode |=> $stable(faultBits));

  // R8
  test_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    testMode |-> (ramWrData == wrData && rdData == ramRdData));

  // R9
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ramWrData & keepMask) == (wrData & keepMask)) &&
    ((rdData & keepMask) == (ramRdData & keepMask)));

endmodule

bind faultSwapRepair repairChecker #(
  .DATA_W(DATA_W), .FIELD_W(FIELD_W), .FAULT_BITS(FAULT_BITS),
  .HI_POS(HI_POS), .LO_POS(LO_POS)
) chk_i (
  .clk(clk), .rstN(rstN), .testMode(testMode), .bistErr(bistErr),
  .bistErrWord(bistErrWord), .wrData(wrData), .ramWrData(ramWrData),
  .ramRdData(ramRdData), .rdData(rdData), .faultBits(faultBits)
);

// File: tb/faultSwapRepair_tb.sv
module faultSwapRepair_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 1024;
  localparam int GRP  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        testMode = 1'b0;
  logic        bistErr = 1'b0;
  logic [9:0]  bistRow = '0;
  logic [14:0] bistErrWord = '0;
  logic [9:0]  wrRow = '0;
  logic [14:0] wrData = '0;
  logic [14:0] ramWrData;
  logic [9:0]  rdRow = '0;
  logic [14:0] ramRdData = '0;
  logic [14:0] rdData;

  int totalCount = 0;
  int failCount  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  faultSwapRepair #(.ROWS(ROWS), .ROWS_PER_BIT(GRP)) dut_i (
    .clk(clk), .rstN(rstN), .testMode(testMode), .bistErr(bistErr),
    .bistRow(bistRow), .bistErrWord(bistErrWord), .wrRow(wrRow),
    .wrData(wrData), .ramWrData(ramWrData), .rdRow(rdRow),
    .ramRdData(ramRdData), .rdData(rdData)
  );

  localparam logic [14:0] PAT  = 15'h6A5B;
  localparam logic [14:0] PAT2 = 15'h1C27;

  // {row[9:0], errWord[14:0], expectMarked}
  localparam logic [25:0] VEC [8] = '{
    {10'd8,    15'h4000, 1'b1},  // R4 I5 only
    {10'd20,   15'h0002, 1'b0},  // R5 low only
    {10'd40,   15'h4002, 1'b0},  // R5 both fields
    {10'd60,   15'h0001, 1'b0},  // R5 neither (bit 0)
    {10'd100,  15'h0004, 1'b1},  // R4 CN2
    {10'd1023, 15'h0040, 1'b1},  // R4 last group
    {10'd0,    15'h1000, 1'b1},  // R4 first row
    {10'd200,  15'h0000, 1'b0}   // R5 empty word
  };

  function automatic logic [14:0] swapRef(logic [14:0] d);
    logic [14:0] o;
    o = d;
    o[14:12] = d[11:9]; o[11:9] = d[14:12];
    o[8:6]   = d[5:3];  o[5:3]  = d[8:6];
    o[2]     = d[1];    o[1]    = d[2];
    return o;
  endfunction

  task automatic chk(string req, logic [14:0] act, logic [14:0] exp);
    totalCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic capture(logic [9:0] row, logic [14:0] word, logic flag);
    @(negedge clk);
    bistRow = row; bistErrWord = word; bistErr = flag;
    @(negedge clk);
    bistErr = 1'b0; bistErrWord = '0;
  endtask

  task automatic setMode(logic m);
    @(negedge clk);
    testMode = m;
  endtask

  task automatic checkWr(string req, logic [9:0] row, logic [14:0] d, logic marked);
    @(negedge clk);
    wrRow = row; wrData = d;
    #1;
    chk(req, ramWrData, marked ? swapRef(d) : d);
  endtask

  task automatic checkRd(string req, logic [9:0] row, logic [14:0] ram, logic marked);
    @(negedge clk);
    rdRow = row; ramRdData = ram;
    #1;
    chk(req, rdData, marked ? swapRef(ram) : ram);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failCount++; totalCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", totalCount - failCount, totalCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2: reset state, no row swaps
    checkWr("R2", 10'd8, PAT, 1'b0);
    checkRd("R2", 10'd1023, PAT, 1'b0);

    // session 1: walk the vector table
    setMode(1'b1);
    for (int v = 0; v < 8; v++) capture(VEC[v][25:16], VEC[v][15:1], 1'b1);
    // R5: bistErr low with a high-field word is ignored
    capture(10'd300, 15'h4000, 1'b0);
    // R10: low-only capture on already marked row 8 keeps it
    capture(10'd8, 15'h0800, 1'b1);
    // R8: in test mode a marked row passes unchanged
    checkWr("R8", 10'd8, PAT, 1'b0);
    checkRd("R8", 10'd8, PAT, 1'b0);
    setMode(1'b0);

    for (int v = 0; v < 8; v++) begin
      checkWr(VEC[v][0] ? "R6" : "R5", VEC[v][25:16], PAT, VEC[v][0]);
      checkRd("R7", VEC[v][25:16], swapRef(PAT), VEC[v][0]);
      if (VEC[v][0]) chk("R7", rdData, PAT);
    end
    checkWr("R5", 10'd300, PAT, 1'b0);
    // R1: group sharing with 4 rows per flag
    checkWr("R1", 10'd11, PAT2, 1'b1);
    checkWr("R1", 10'd12, PAT2, 1'b0);
    checkWr("R1", 10'd1020, PAT2, 1'b1);
    // R9: bit 0 stays in place on a marked row
    checkWr("R9", 10'd9, 15'h0001, 1'b1);
    chk("R9", ramWrData & 15'h0001, 15'h0001);
    // write and read on different rows in one cycle
    @(negedge clk);
    wrRow = 10'd100; wrData = PAT; rdRow = 10'd40; ramRdData = PAT2;
    #1;
    chk("R6", ramWrData, swapRef(PAT));
    chk("R8", rdData, PAT2);
    // R10: flags persist over idle functional cycles
    repeat (20) @(negedge clk);
    checkWr("R10", 10'd0, PAT, 1'b1);

    // R3: entry clear coinciding with a capture on row 500
    @(negedge clk);
    testMode = 1'b1; bistRow = 10'd500; bistErrWord = 15'h0080; bistErr = 1'b1;
    @(negedge clk);
    bistErr = 1'b0; bistErrWord = '0;
    setMode(1'b0);
    checkWr("R3", 10'd500, PAT, 1'b1);
    checkWr("R3", 10'd8, PAT, 1'b0);
    checkWr("R3", 10'd1023, PAT, 1'b0);

    // R2: reset in functional mode clears the new flag
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    checkWr("R2", 10'd500, PAT, 1'b0);

    $display("%0d/%0d checks passed", totalCount - failCount, totalCount);
    $finish;
  end

endmodule